// File: doc/BRIEF.md
# Pixel Bit-Depth Reduction Unit

This block sits in a video output pipeline and narrows each component of a three-channel pixel stream (RGB or YCbCr, 12 bits per channel) to fewer significant bits before it leaves for a link or panel that carries only 6, 8 or 10 bits per component. It can do this in two ways. Plain truncation clears the discarded low bits. Spatial dithering first adds pseudo-random noise, confined to the discarded bits, and then clears them. The reduced value always comes out left-aligned in the 12-bit field, with zeros below.

Each channel has its own 28-bit linear feedback shift register as its noise source, with a seed of its own. An option lets all three channels share the red generator, so that the same noise pattern lands on every channel. A frame-random option adds a per-frame counter to the noise. Its wrap value and bit shuffling depend on the dither depth, so the pattern moves from frame to frame. All configuration is captured on the first pixel of a frame and holds for the whole frame.

The stream uses a valid/ready handshake with frame-start and line-start markers. Results appear one cycle after a pixel is accepted, and the ready signal passes straight through from the downstream side.

Top module: `pix_depth_reducer`

## Requirements
- R1: With truncation enabled and dithering disabled, each output channel equals its input with the low 6 bits cleared when the truncate-depth input is 0, and with the low 4 bits cleared when it is 1.
- R2: With both truncation and dithering disabled, each output channel equals its input bit for bit.
- R3: With dithering enabled (which takes priority over truncation), the number of discarded bits D is 6, 4 or 2 for dither-depth codes 0, 1 and 2-or-3. Each channel outputs min(x + (n AND (2^D-1)), 4095) with its low D bits cleared. Here n is that channel's 12-bit noise word.
- R4: Each noise generator holds a 28-bit state s that steps to {s[26:0], s[27] XOR s[2]} (polynomial x^28+x^3+1) once per accepted pixel. The noise word for a pixel is bits [11:0] of the state before that step, XOR the frame perturbation.
- R5: On an accepted frame-start pixel where dithering turns on (off in the previous frame's captured configuration, on in the new one), all three generators load their seed inputs. That pixel uses the seed itself as its state.
- R6: With the shared-noise option set, all three channels take their noise from the red generator's state.
- R7: With frame-random set, a 4-bit frame counter advances on each accepted frame-start pixel and returns to 0 after 15 (dither depth 0 or 1) or after 3 (depth 2 or 3); a count above the limit also returns to 0. The perturbation is the counter with its 4 bits reversed (depth 0/1) or its low 2 bits swapped ({c0,c1}, depth 2/3). With frame-random clear, the counter is forced to 0 and adds nothing.
- R8: Configuration inputs are captured on each accepted frame-start pixel and used for that pixel and the rest of its frame; changes to them on other pixels have no effect on outputs.
- R9: in_ready equals out_ready; when out_ready is high, out_valid one cycle later equals in_valid, and out_sof/out_sol carry the accepted pixel's markers; when out_ready is low, all outputs hold; after reset out_valid is 0.
- R10: When a dithered sum exceeds 4095 the channel saturates at 4095 before the low bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sof | input | 1 | Pixel is first of a frame |
| in_sol | input | 1 | Pixel is first of a line |
| in_r | input | 12 | Red / Cr channel |
| in_g | input | 12 | Green / Y channel |
| in_b | input | 12 | Blue / Cb channel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_sof | output | 1 | Frame-start marker of output pixel |
| out_sol | output | 1 | Line-start marker of output pixel |
| out_r | output | 12 | Reduced red channel |
| out_g | output | 12 | Reduced green channel |
| out_b | output | 12 | Reduced blue channel |
| cfg_trunc_en | input | 1 | Truncation enable |
| cfg_trunc_depth | input | 1 | 0: keep 6 bits, 1: keep 8 bits |
| cfg_dith_en | input | 1 | Spatial dither enable |
| cfg_dith_depth | input | 2 | 0: 6 bits, 1: 8 bits, 2/3: 10 bits |
| cfg_frame_rand | input | 1 | Per-frame noise perturbation enable |
| cfg_rgb_rand | input | 1 | All channels share the red noise generator |
| cfg_seed_r | input | 28 | Red generator seed |
| cfg_seed_g | input | 28 | Green generator seed |
| cfg_seed_b | input | 28 | Blue generator seed |

## Verification
The assertions assume that a source holds a pixel steady while in_ready is low, that in_sof marks the first pixel of each frame, and that reset is held for at least one clock edge. Under those assumptions they check handshake timing, the generator step and seed load, and the frame counter. The stimulus keeps every pixel and its markers stable until it is accepted, and always starts a frame with a frame-start pixel. It toggles out_ready and inserts idle cycles at random. It changes configuration inputs in the middle of frames only to show that they are ignored there.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int PDR_CH_W   = 12;
  localparam int PDR_LFSR_W = 28;
  localparam int PDR_TAP    = 2;
  localparam int PDR_FC_W   = 4;

  typedef logic [PDR_CH_W-1:0]   pdr_px_t;
  typedef logic [PDR_LFSR_W-1:0] pdr_lfsr_t;

  typedef struct packed {
    logic       trunc_en;
    logic       trunc_depth;
    logic       dith_en;
    logic [1:0] dith_depth;
    logic       frame_rand;
    logic       rgb_rand;
  } pdr_cfg_t;

  // x^28 + x^3 + 1, shifting toward the MSB
  function automatic pdr_lfsr_t pdr_lfsr_next(pdr_lfsr_t s);
    return {s[PDR_LFSR_W-2:0], s[PDR_LFSR_W-1] ^ s[PDR_TAP]};
  endfunction

  function automatic int unsigned pdr_trunc_drop(logic depth);
    return depth ? 4 : 6;
  endfunction

  function automatic int unsigned pdr_dith_drop(logic [1:0] depth);
    case (depth)
      2'd0:    return 6;
      2'd1:    return 4;
      default: return 2;
    endcase
  endfunction

  function automatic pdr_px_t pdr_low_mask(int unsigned n);
    pdr_px_t m;
    for (int i = 0; i < PDR_CH_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic [PDR_FC_W-1:0] pdr_fc_limit(logic [1:0] depth);
    return (depth < 2'd2) ? 4'd15 : 4'd3;
  endfunction

  function automatic logic [PDR_FC_W-1:0] pdr_fc_swizzle(logic [1:0] depth,
                                                         logic [PDR_FC_W-1:0] fc);
    if (depth < 2'd2) return {fc[0], fc[1], fc[2], fc[3]};
    return {2'b00, fc[0], fc[1]};
  endfunction

  function automatic pdr_px_t pdr_dither(pdr_px_t x, pdr_px_t noise, int unsigned drop);
    pdr_px_t           m;
    logic [PDR_CH_W:0] sum;
    pdr_px_t           sat;
    m   = pdr_low_mask(drop);
    sum = {1'b0, x} + {1'b0, noise & m};
    sat = sum[PDR_CH_W] ? '1 : sum[PDR_CH_W-1:0];
    return sat & ~m;
  endfunction

  function automatic pdr_px_t pdr_truncate(pdr_px_t x, int unsigned drop);
    return x & ~pdr_low_mask(drop);
  endfunction
endpackage

// File: rtl/pdr_cfg_sampler.sv
module pdr_cfg_sampler
  import pdr_pkg::*;
#(
  parameter int FC_W = PDR_FC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_acc,
  input  pdr_cfg_t        cfg_in,
  output pdr_cfg_t        eff_cfg,
  output logic            reload_ev,
  output logic [FC_W-1:0] fc_eff,
  output logic [FC_W-1:0] fc_q
);
  pdr_cfg_t        act_q;
  logic [FC_W-1:0] fc_next;

  always_comb begin
    if (!cfg_in.frame_rand)
      fc_next = '0;
    else if (fc_q >= pdr_fc_limit(cfg_in.dith_depth))
      fc_next = '0;
    else
      fc_next = fc_q + 1'b1;
  end

  assign eff_cfg   = sof_acc ? cfg_in : act_q;
  assign fc_eff    = sof_acc ? fc_next : fc_q;
  assign reload_ev = sof_acc & cfg_in.dith_en & ~act_q.dith_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      fc_q  <= '0;
    end else if (sof_acc) begin
      act_q <= cfg_in;
      fc_q  <= fc_next;
    end
  end
endmodule

// File: rtl/pdr_noise_bank.sv
module pdr_noise_bank
  import pdr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int LFSR_W = PDR_LFSR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              reload_ev,
  input  logic [LFSR_W-1:0] seed  [NUM_CH],
  output logic [LFSR_W-1:0] cur   [NUM_CH],
  output logic [LFSR_W-1:0] state [NUM_CH]
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gen
    assign cur[ch] = reload_ev ? seed[ch] : state[ch];

    always_ff @(posedge clk) begin
      if (!rst_n)
        state[ch] <= LFSR_W'(1);
      else if (acc)
        state[ch] <= pdr_lfsr_next(cur[ch]);
    end
  end
endmodule

// File: rtl/pdr_chan_reduce.sv
module pdr_chan_reduce
  import pdr_pkg::*;
#(
  parameter int FC_W = PDR_FC_W
) (
  input  pdr_px_t         x,
  input  pdr_px_t         noise,
  input  logic [FC_W-1:0] perturb,
  input  pdr_cfg_t        cfg,
  output pdr_px_t         y
);
  pdr_px_t noise_p;

  assign noise_p = noise ^ pdr_px_t'(perturb);

  always_comb begin
    if (cfg.dith_en)
      y = pdr_dither(x, noise_p, pdr_dith_drop(cfg.dith_depth));
    else if (cfg.trunc_en)
      y = pdr_truncate(x, pdr_trunc_drop(cfg.trunc_depth));
    else
      y = x;
  end
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer
  import pdr_pkg::*;
#(
  parameter int CH_W   = PDR_CH_W,
  parameter int LFSR_W = PDR_LFSR_W,
  parameter int FC_W   = PDR_FC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic [CH_W-1:0]   in_r,
  input  logic [CH_W-1:0]   in_g,
  input  logic [CH_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic              out_sol,
  output logic [CH_W-1:0]   out_r,
  output logic [CH_W-1:0]   out_g,
  output logic [CH_W-1:0]   out_b,
  input  logic              cfg_trunc_en,
  input  logic              cfg_trunc_depth,
  input  logic              cfg_dith_en,
  input  logic [1:0]        cfg_dith_depth,
  input  logic              cfg_frame_rand,
  input  logic              cfg_rgb_rand,
  input  logic [LFSR_W-1:0] cfg_seed_r,
  input  logic [LFSR_W-1:0] cfg_seed_g,
  input  logic [LFSR_W-1:0] cfg_seed_b
);
  localparam int NUM_CH = 3;

  // named events for the checker
  logic            acc;
  logic            sof_acc;
  logic            reload_ev;
  pdr_cfg_t        cfg_in;
  pdr_cfg_t        eff_cfg;
  logic [FC_W-1:0] fc_eff;
  logic [FC_W-1:0] fc_q;
  logic [FC_W-1:0] perturb;

  logic [LFSR_W-1:0] seed_a  [NUM_CH];
  logic [LFSR_W-1:0] cur_a   [NUM_CH];
  logic [LFSR_W-1:0] state_a [NUM_CH];
  logic [CH_W-1:0]   px_in   [NUM_CH];
  logic [CH_W-1:0]   px_red  [NUM_CH];

  assign in_ready = out_ready;
  assign acc      = in_valid & out_ready;
  assign sof_acc  = acc & in_sof;

  assign cfg_in = '{trunc_en:    cfg_trunc_en,
                    trunc_depth: cfg_trunc_depth,
                    dith_en:     cfg_dith_en,
                    dith_depth:  cfg_dith_depth,
                    frame_rand:  cfg_frame_rand,
                    rgb_rand:    cfg_rgb_rand};

  assign seed_a[0] = cfg_seed_r;
  assign seed_a[1] = cfg_seed_g;
  assign seed_a[2] = cfg_seed_b;
  assign px_in[0]  = in_r;
  assign px_in[1]  = in_g;
  assign px_in[2]  = in_b;

  pdr_cfg_sampler #(.FC_W(FC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_acc   (sof_acc),
    .cfg_in    (cfg_in),
    .eff_cfg   (eff_cfg),
    .reload_ev (reload_ev),
    .fc_eff    (fc_eff),
    .fc_q      (fc_q)
  );

  assign perturb = pdr_fc_swizzle(eff_cfg.dith_depth, fc_eff);

  pdr_noise_bank #(.NUM_CH(NUM_CH), .LFSR_W(LFSR_W)) u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .reload_ev (reload_ev),
    .seed      (seed_a),
    .cur       (cur_a),
    .state     (state_a)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CH_W-1:0] noise_sel;
    assign noise_sel = eff_cfg.rgb_rand ? cur_a[0][CH_W-1:0] : cur_a[ch][CH_W-1:0];

    pdr_chan_reduce #(.FC_W(FC_W)) u_red (
      .x       (px_in[ch]),
      .noise   (noise_sel),
      .perturb (perturb),
      .cfg     (eff_cfg),
      .y       (px_red[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      if (out_ready) out_valid <= in_valid;
      if (acc) begin
        out_sof <= in_sof;
        out_sol <= in_sol;
        out_r   <= px_red[0];
        out_g   <= px_red[1];
        out_b   <= px_red[2];
      end
    end
  end
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker
  import pdr_pkg::*;
#(
  parameter int CH_W   = PDR_CH_W,
  parameter int LFSR_W = PDR_LFSR_W,
  parameter int FC_W   = PDR_FC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CH_W-1:0]   in_r,
  input logic              out_ready,
  input logic              out_valid,
  input logic [CH_W-1:0]   out_r,
  input logic              acc,
  input logic              sof_acc,
  input logic              reload_ev,
  input logic              eff_trunc_en,
  input logic              eff_dith_en,
  input logic              eff_frame_rand,
  input logic [1:0]        eff_dith_depth,
  input logic [FC_W-1:0]   fc_q,
  input logic [LFSR_W-1:0] lfsr_r,
  input logic [LFSR_W-1:0] seed_r
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(out_valid) && $stable(out_r));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> out_valid == $past(in_valid));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !eff_trunc_en && !eff_dith_en |=> out_r == $past(in_r));

  p_trunc_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && eff_trunc_en && !eff_dith_en |=> out_r[3:0] == 4'd0);

  p_lfsr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !reload_ev |=> lfsr_r == pdr_lfsr_next($past(lfsr_r)));

  p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev |=> lfsr_r == pdr_lfsr_next($past(seed_r)));

  p_fc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_acc && !eff_frame_rand |=> fc_q == '0);

  p_fc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_acc && eff_frame_rand |=>
      fc_q <= (($past(eff_dith_depth) < 2'd2) ? 4'd15 : 4'd3));
endmodule

bind pix_depth_reducer pdr_checker #(.CH_W(CH_W), .LFSR_W(LFSR_W), .FC_W(FC_W)) u_pdr_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_r           (in_r),
  .out_ready      (out_ready),
  .out_valid      (out_valid),
  .out_r          (out_r),
  .acc            (acc),
  .sof_acc        (sof_acc),
  .reload_ev      (reload_ev),
  .eff_trunc_en   (eff_cfg.trunc_en),
  .eff_dith_en    (eff_cfg.dith_en),
  .eff_frame_rand (eff_cfg.frame_rand),
  .eff_dith_depth (eff_cfg.dith_depth),
  .fc_q           (fc_q),
  .lfsr_r         (state_a[0]),
  .seed_r         (cfg_seed_r)
);

// File: tb/pix_depth_reducer_tb_top.sv
module pix_depth_reducer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sof, in_sol;
  logic [11:0] in_r, in_g, in_b;
  logic        out_valid, out_ready, out_sof, out_sol;
  logic [11:0] out_r, out_g, out_b;
  logic        cfg_trunc_en, cfg_trunc_depth, cfg_dith_en;
  logic [1:0]  cfg_dith_depth;
  logic        cfg_frame_rand, cfg_rgb_rand;
  logic [27:0] cfg_seed_r, cfg_seed_g, cfg_seed_b;

  always #5 clk = ~clk;

  pix_depth_reducer dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  bit          m_dith, m_trunc, m_tdep, m_fr, m_rgb;
  int unsigned m_ddep;
  int unsigned m_fc;
  int unsigned m_s [3];
  bit          e_valid, e_sof, e_sol;
  int unsigned e_px [3];
  string       e_tag;
  string       force_tag = "";

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned step28(int unsigned s);
    int unsigned fb = ((s >> 27) ^ (s >> 2)) & 1;
    return ((s << 1) | fb) & 32'h0FFF_FFFF;
  endfunction

  function automatic int unsigned pert(int unsigned dep, int unsigned fc);
    int unsigned p = 0;
    if (dep < 2) begin
      for (int i = 0; i < 4; i++) if ((fc >> i) & 1) p |= (1 << (3 - i));
    end else begin
      p = ((fc & 1) << 1) | ((fc >> 1) & 1);
    end
    return p;
  endfunction

  function automatic int unsigned ref_chan(int unsigned x, int unsigned noise);
    int unsigned drop, v;
    if (m_dith) begin
      drop = (m_ddep == 0) ? 6 : (m_ddep == 1) ? 4 : 2;
      v = x + (noise & ((1 << drop) - 1));
      if (v > 4095) v = 4095;
      return (v >> drop) << drop;
    end
    if (m_trunc) begin
      drop = m_tdep ? 4 : 6;
      return (x >> drop) << drop;
    end
    return x;
  endfunction

  // applies the effect of the coming clock edge to the model
  task automatic model_edge();
    bit reload = 0;
    int unsigned p;
    if (!out_ready) return;
    e_valid = in_valid;
    if (!in_valid) return;
    if (in_sof) begin
      reload  = cfg_dith_en && !m_dith;
      m_dith  = cfg_dith_en;  m_trunc = cfg_trunc_en; m_tdep = cfg_trunc_depth;
      m_ddep  = cfg_dith_depth; m_fr = cfg_frame_rand; m_rgb = cfg_rgb_rand;
      if (!m_fr) m_fc = 0;
      else if (m_fc >= ((m_ddep < 2) ? 15 : 3)) m_fc = 0;
      else m_fc = m_fc + 1;
    end
    if (reload) begin
      m_s[0] = cfg_seed_r; m_s[1] = cfg_seed_g; m_s[2] = cfg_seed_b;
    end
    p = pert(m_ddep, m_fc);
    e_px[0] = ref_chan(in_r, (m_s[0] ^ p) & 12'hFFF);
    e_px[1] = ref_chan(in_g, (m_s[m_rgb ? 0 : 1] ^ p) & 12'hFFF);
    e_px[2] = ref_chan(in_b, (m_s[m_rgb ? 0 : 2] ^ p) & 12'hFFF);
    e_sof = in_sof; e_sol = in_sol;
    if (force_tag != "")       e_tag = force_tag;
    else if (reload)           e_tag = "R5";
    else if (m_dith && m_rgb)  e_tag = "R6";
    else if (m_dith && m_fr)   e_tag = "R7";
    else if (m_dith)           e_tag = "R3 R4";
    else if (m_trunc)          e_tag = "R1";
    else                       e_tag = "R2";
    for (int c = 0; c < 3; c++) m_s[c] = step28(m_s[c]);
  endtask

  task automatic check_out();
    chk(in_ready == out_ready, "R9 ready", in_ready, out_ready);
    chk(out_valid == e_valid, "R9 valid", out_valid, e_valid);
    if (e_valid) begin
      chk(out_sof == e_sof && out_sol == e_sol, "R9 markers", {out_sof, out_sol}, {e_sof, e_sol});
      chk(out_r == e_px[0], {e_tag, " red"},   out_r, e_px[0]);
      chk(out_g == e_px[1], {e_tag, " green"}, out_g, e_px[1]);
      chk(out_b == e_px[2], {e_tag, " blue"},  out_b, e_px[2]);
    end
  endtask

  // one clock: called at a negedge with inputs set
  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic send_pixel(bit sof, bit sol, int unsigned r, int unsigned g, int unsigned b);
    if ($urandom % 5 == 0) begin
      in_valid = 0; in_r = 12'($urandom); in_sof = 0; in_sol = 0;
      out_ready = ($urandom % 8) != 0;
      tick();
    end
    in_valid = 1; in_sof = sof; in_sol = sol;
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
    forever begin
      out_ready = ($urandom % 8) != 0;
      if (out_ready) begin
        tick();
        break;
      end
      tick();
    end
    in_valid = 0;
  endtask

  task automatic set_cfg(bit te, bit td, bit de, int unsigned dd, bit fr, bit rg);
    cfg_trunc_en = te; cfg_trunc_depth = td; cfg_dith_en = de;
    cfg_dith_depth = 2'(dd); cfg_frame_rand = fr; cfg_rgb_rand = rg;
    cfg_seed_r = 28'($urandom) | 28'd1;
    cfg_seed_g = 28'($urandom) | 28'd1;
    cfg_seed_b = 28'($urandom) | 28'd1;
  endtask

  task automatic rand_cfg();
    set_cfg(1'($urandom), 1'($urandom), 1'($urandom), $urandom % 4, 1'($urandom), 1'($urandom));
  endtask

  function automatic int unsigned rpx();
    return ($urandom % 3 == 0) ? 4095 - ($urandom % 40) : $urandom % 4096;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_sof = 0; in_sol = 0; out_ready = 1;
    in_r = 0; in_g = 0; in_b = 0;
    set_cfg(0, 0, 0, 0, 0, 0);
    m_dith = 0; m_trunc = 0; m_tdep = 0; m_ddep = 0; m_fr = 0; m_rgb = 0; m_fc = 0;
    for (int c = 0; c < 3; c++) m_s[c] = 1;
    e_valid = 0; e_tag = "R2";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset", out_valid, 0);
    rst_n = 1;

    for (int f = 0; f < 90; f++) begin
      int unsigned npx = (f < 28) ? 6 : 12;
      force_tag = "";
      if (f < 20)       set_cfg(0, 0, 1, (f < 10) ? 0 : 1, 1, 0);  // long wrap
      else if (f < 28)  set_cfg(1, 0, 1, 2, 1, 0);                 // short wrap, dither beats trunc
      else if (f == 28) begin set_cfg(0, 0, 1, 0, 0, 0); force_tag = "R10"; end
      else if (f == 29) begin set_cfg(0, 0, 0, 0, 0, 0); force_tag = "R8"; end
      else if (f == 30) begin set_cfg(1, 0, 0, 0, 0, 0); force_tag = "R1"; end
      else if (f == 31) begin set_cfg(1, 1, 0, 0, 0, 0); force_tag = "R1"; end
      else if (f == 32) begin set_cfg(0, 0, 0, 0, 0, 0); force_tag = "R2"; end
      else if (f == 33) begin set_cfg(0, 0, 1, 1, 0, 1); force_tag = ""; end
      else rand_cfg();
      for (int p = 0; p < int'(npx); p++) begin
        if (p == 1 && (f == 29 || f >= 34)) rand_cfg();   // mid-frame changes must not matter
        if (f == 28) send_pixel(p == 0, p % 4 == 0, 4095 - p, 4095, 4064 + p);
        else         send_pixel(p == 0, p % 4 == 0, rpx(), rpx(), rpx());
      end
      if (f == 29) set_cfg(0, 0, 0, 0, 0, 0);
    end
    out_ready = 1; in_valid = 0;
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule